// File: doc/BRIEF.md
# Serial Audio Link Power Sequencer

This block is the controller-side sequencer that takes a frame-based serial audio link (frame sync, bit clock, outbound and inbound serial data) into and out of its low-power state. It sits between the command and data sources and the frame serializer. While the link runs, it passes the command slot and the data slots through unchanged. When power-down is requested, it replaces the command slot with a write that sets the peripheral's link power-down bit and silences every data slot for that frame. After the frame, it treats the bit clock as gone.

While the link sleeps, the sequencer watches the inbound data line in a free-running reference clock domain. A rising edge that stays high for longer than one microsecond is a wake request. It raises a sticky resume interrupt if resume is enabled. On command, the block drives the frame-sync line high for exactly one microsecond of reference cycles as a warm reset. It then waits for bit clock edges to come back before it reports the link as running again. Both asynchronous inputs pass through two-flop synchronizers before any edge is detected.

Top module: `alink_pwr_seq`

## Requirements
- R1: After reset, `link_active` is 1, `sync_out` is 0 and `resume_irq` is 0.
- R2: While `link_active` is 1, every command and data slot output equals its input in the same cycle.
- R3: A `pd_req` pulse while running starts the power-down frame from the next clock edge until `frame_done`. During that frame the command outputs are write=1, address 0x26 and data 0x1000, and all data slots and their valid bits are 0, whatever the inputs are.
- R4: After the `frame_done` edge that ends the power-down frame, `link_active` is 0 and all slot outputs stay 0. Bit clock activity in this state has no effect.
- R5: An inbound data pulse shorter than the qualification time raises no interrupt.
- R6: When inbound data rises at the sleep-state input and stays high, the wake request qualifies at the (4+US_CYC)-th reference edge after the first sampling edge. `resume_irq` is 1 from that edge on when `resume_en` is 1.
- R7: With `resume_en` at 0, a qualified wake request leaves `resume_irq` at 0.
- R8: `resume_irq` stays 1 until a cycle with `resume_clr` at 1 clears it at the next edge. A new wake qualification in the same cycle as a clear wins.
- R9: A `warm_go` pulse while asleep or after a qualified wake drives `sync_out` high from the next edge for exactly US_CYC reference cycles.
- R10: After `sync_out` falls, `link_active` returns to 1 only once EDGE_N rising bit clock edges have been seen.
- R11: `pd_req` while the link is not running, and inbound data edges while it is running, have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst | input | 1 | Synchronous active-high reset |
| pd_req | input | 1 | Request link power-down (pulse) |
| frame_done | input | 1 | Serializer finished the current frame (pulse) |
| warm_go | input | 1 | Command a warm-reset pulse (pulse) |
| resume_en | input | 1 | Allow a wake request to raise the interrupt |
| resume_clr | input | 1 | Write-one-to-clear for the resume interrupt |
| sdata_in | input | 1 | Inbound serial data line, asynchronous |
| bitclk_in | input | 1 | Link bit clock, asynchronous |
| cmd_wr_in | input | 1 | Command slot write flag from the source |
| cmd_addr_in | input | 7 | Command slot register address from the source |
| cmd_data_in | input | 16 | Command slot write data from the source |
| dslot_in | input | NSLOT*SW | Data slots from the source, slot 0 in the low bits |
| dslot_vld_in | input | NSLOT | Data slot valid flags from the source |
| cmd_wr_out | output | 1 | Command slot write flag to the serializer |
| cmd_addr_out | output | 7 | Command slot address to the serializer |
| cmd_data_out | output | 16 | Command slot data to the serializer |
| dslot_out | output | NSLOT*SW | Data slots to the serializer |
| dslot_vld_out | output | NSLOT | Data slot valid flags to the serializer |
| sync_out | output | 1 | Warm-reset drive for the frame-sync line |
| resume_irq | output | 1 | Sticky resume interrupt |
| link_active | output | 1 | Link running; serializer may operate |

## Verification
Slot outputs are combinational from the state register. They are checked one settle delay after the inputs change, or at the falling edge after the edge that moves the state. A wake pulse reaches the state machine three reference edges after it is first sampled and qualifies US_CYC+1 edges later. The bench therefore samples `resume_irq` at the falling edges on each side of edge 4+US_CYC. The warm-reset pulse is checked one falling edge after its start, after its US_CYC-th cycle, and after its end. Bit clock recovery goes through the synchronizer and an edge counter, so `link_active` is sampled several cycles after the last needed bit clock edge and also before it.

// File: rtl/alink_pwr_pkg.sv
package alink_pwr_pkg;

    localparam int CMD_AW = 7;
    localparam int CMD_DW = 16;

    localparam logic [CMD_AW-1:0] PD_REG_ADDR = 7'h26;
    localparam logic [CMD_DW-1:0] PD_REG_DATA = 16'h1000;

    typedef enum logic [2:0] {
        LS_RUN,
        LS_PDWR,
        LS_DOZE,
        LS_WAKE,
        LS_WRST,
        LS_CLKWAIT
    } lp_state_e;

    typedef enum logic [1:0] {
        GM_PASS,
        GM_PDWR,
        GM_MUTE
    } gate_mode_e;

    typedef struct packed {
        logic              wr;
        logic [CMD_AW-1:0] addr;
        logic [CMD_DW-1:0] data;
    } cmd_slot_t;

    function automatic gate_mode_e gate_mode(lp_state_e st);
        case (st)
            LS_RUN:  return GM_PASS;
            LS_PDWR: return GM_PDWR;
            default: return GM_MUTE;
        endcase
    endfunction

endpackage

// File: rtl/alink_sync.sv
module alink_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic [STAGES-1:0] sh;
        always_ff @(posedge clk) begin
            if (rst) sh <= '0;
            else     sh <= {sh[STAGES-2:0], d[i]};
        end
        assign q[i] = sh[STAGES-1];
    end
endmodule

// File: rtl/alink_span_cnt.sv
module alink_span_cnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         en,
    output logic [W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (rst || clr)               cnt <= '0;
        else if (en && cnt != '1)     cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/alink_slot_gate.sv
module alink_slot_gate
    import alink_pwr_pkg::*;
#(
    parameter int NSLOT = 10,
    parameter int SW    = 20
) (
    input  gate_mode_e              mode,
    input  cmd_slot_t               cmd_in,
    input  logic [NSLOT*SW-1:0]     dslot_in,
    input  logic [NSLOT-1:0]        vld_in,
    output cmd_slot_t               cmd_out,
    output logic [NSLOT*SW-1:0]     dslot_out,
    output logic [NSLOT-1:0]        vld_out
);
    logic keep_data;
    assign keep_data = (mode == GM_PASS);

    always_comb begin
        case (mode)
            GM_PASS: cmd_out = cmd_in;
            GM_PDWR: cmd_out = '{wr: 1'b1, addr: PD_REG_ADDR, data: PD_REG_DATA};
            default: cmd_out = '0;
        endcase
    end

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        assign dslot_out[g*SW +: SW] = keep_data ? dslot_in[g*SW +: SW] : '0;
        assign vld_out[g]            = keep_data & vld_in[g];
    end
endmodule

// File: rtl/alink_pwr_seq.sv
module alink_pwr_seq
    import alink_pwr_pkg::*;
#(
    parameter int US_CYC      = 50,
    parameter int EDGE_N      = 2,
    parameter int NSLOT       = 10,
    parameter int SW          = 20,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 pd_req,
    input  logic                 frame_done,
    input  logic                 warm_go,
    input  logic                 resume_en,
    input  logic                 resume_clr,
    input  logic                 sdata_in,
    input  logic                 bitclk_in,
    input  logic                 cmd_wr_in,
    input  logic [6:0]           cmd_addr_in,
    input  logic [15:0]          cmd_data_in,
    input  logic [NSLOT*SW-1:0]  dslot_in,
    input  logic [NSLOT-1:0]     dslot_vld_in,
    output logic                 cmd_wr_out,
    output logic [6:0]           cmd_addr_out,
    output logic [15:0]          cmd_data_out,
    output logic [NSLOT*SW-1:0]  dslot_out,
    output logic [NSLOT-1:0]     dslot_vld_out,
    output logic                 sync_out,
    output logic                 resume_irq,
    output logic                 link_active
);
    localparam int US_W = $clog2(US_CYC + 1) + 1;
    localparam int ED_W = $clog2(EDGE_N + 1) + 1;
    localparam logic [US_W-1:0] QUAL_LIM = US_W'(US_CYC);
    localparam logic [US_W-1:0] WARM_LIM = US_W'(US_CYC - 1);
    localparam logic [ED_W-1:0] EDGE_LIM = ED_W'(EDGE_N);

    lp_state_e st_q, st_d;
    logic      qual_q;
    logic      irq_q;

    // synchronized async inputs: bit 0 = inbound data, bit 1 = bit clock
    logic [1:0] raw_async, syn_async, syn_prev;
    logic       sd_s, sd_rise, bc_rise;

    assign raw_async = {bitclk_in, sdata_in};

    alink_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_async),
        .q   (syn_async)
    );

    always_ff @(posedge clk) begin
        if (rst) syn_prev <= '0;
        else     syn_prev <= syn_async;
    end

    assign sd_s    = syn_async[0];
    assign sd_rise = syn_async[0] & ~syn_prev[0];
    assign bc_rise = syn_async[1] & ~syn_prev[1];

    // timers
    logic            st_chg;
    logic            us_en, ed_en;
    logic [US_W-1:0] us_cnt;
    logic [ED_W-1:0] ed_cnt;
    logic            qual_set;

    assign st_chg   = (st_d != st_q);
    assign us_en    = ((st_q == LS_WAKE) && !qual_q && sd_s) || (st_q == LS_WRST);
    assign ed_en    = (st_q == LS_CLKWAIT) && bc_rise;
    assign qual_set = (st_q == LS_WAKE) && !qual_q && sd_s && (us_cnt == QUAL_LIM);

    alink_span_cnt #(.W(US_W)) u_us_cnt (
        .clk (clk),
        .rst (rst),
        .clr (st_chg),
        .en  (us_en),
        .cnt (us_cnt)
    );

    alink_span_cnt #(.W(ED_W)) u_edge_cnt (
        .clk (clk),
        .rst (rst),
        .clr (st_chg),
        .en  (ed_en),
        .cnt (ed_cnt)
    );

    // next state
    always_comb begin
        st_d = st_q;
        case (st_q)
            LS_RUN:     if (pd_req) st_d = LS_PDWR;
            LS_PDWR:    if (frame_done) st_d = LS_DOZE;
            LS_DOZE: begin
                if (warm_go)      st_d = LS_WRST;
                else if (sd_rise) st_d = LS_WAKE;
            end
            LS_WAKE: begin
                if (!qual_q) begin
                    if (!sd_s) st_d = LS_DOZE;
                end else if (warm_go) begin
                    st_d = LS_WRST;
                end
            end
            LS_WRST:    if (us_cnt == WARM_LIM) st_d = LS_CLKWAIT;
            LS_CLKWAIT: if (ed_cnt == EDGE_LIM) st_d = LS_RUN;
            default:    st_d = LS_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= LS_RUN;
            qual_q <= 1'b0;
            irq_q  <= 1'b0;
        end else begin
            st_q <= st_d;
            if (st_d != LS_WAKE) qual_q <= 1'b0;
            else if (qual_set)   qual_q <= 1'b1;
            if (qual_set && resume_en) irq_q <= 1'b1;
            else if (resume_clr)       irq_q <= 1'b0;
        end
    end

    // slot path
    cmd_slot_t cmd_in_s, cmd_out_s;
    assign cmd_in_s = '{wr: cmd_wr_in, addr: cmd_addr_in, data: cmd_data_in};

    alink_slot_gate #(.NSLOT(NSLOT), .SW(SW)) u_gate (
        .mode      (gate_mode(st_q)),
        .cmd_in    (cmd_in_s),
        .dslot_in  (dslot_in),
        .vld_in    (dslot_vld_in),
        .cmd_out   (cmd_out_s),
        .dslot_out (dslot_out),
        .vld_out   (dslot_vld_out)
    );

    assign cmd_wr_out   = cmd_out_s.wr;
    assign cmd_addr_out = cmd_out_s.addr;
    assign cmd_data_out = cmd_out_s.data;
    assign sync_out     = (st_q == LS_WRST);
    assign resume_irq   = irq_q;
    assign link_active  = (st_q == LS_RUN);
endmodule

// File: rtl/alink_pwr_seq_chk.sv
module alink_pwr_seq_chk
    import alink_pwr_pkg::*;
#(
    parameter int US_CYC = 50,
    parameter int NSLOT  = 10
) (
    input logic             clk,
    input logic             rst,
    input logic             resume_en,
    input logic             resume_clr,
    input logic             cmd_wr_in,
    input logic [NSLOT-1:0] dslot_vld_in,
    input logic             cmd_wr_out,
    input logic [6:0]       cmd_addr_out,
    input logic [15:0]      cmd_data_out,
    input logic [NSLOT-1:0] dslot_vld_out,
    input logic             sync_out,
    input logic             resume_irq,
    input logic             link_active
);
    localparam int HW = $clog2(US_CYC + 1) + 2;
    logic [HW-1:0] hi_cnt;

    always_ff @(posedge clk) begin
        if (rst)           hi_cnt <= '0;
        else if (sync_out) hi_cnt <= hi_cnt + 1'b1;
        else               hi_cnt <= '0;
    end

    // R2
    run_pass_chk: assert property (@(posedge clk) disable iff (rst)
        link_active |-> (cmd_wr_out == cmd_wr_in && dslot_vld_out == dslot_vld_in));

    // R3
    pd_frame_chk: assert property (@(posedge clk) disable iff (rst)
        (!link_active && cmd_wr_out) |->
        (cmd_addr_out == PD_REG_ADDR && cmd_data_out == PD_REG_DATA && dslot_vld_out == '0));

    // R7
    irq_enable_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(resume_irq) |-> $past(resume_en));

    // R8
    irq_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (resume_irq && !resume_clr) |=> resume_irq);

    // R9
    warm_len_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(sync_out) |-> (hi_cnt == HW'(US_CYC)));

    // R10
    sync_idle_run_chk: assert property (@(posedge clk) disable iff (rst)
        sync_out |-> !link_active);
endmodule

bind alink_pwr_seq alink_pwr_seq_chk #(.US_CYC(US_CYC), .NSLOT(NSLOT)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .resume_en     (resume_en),
    .resume_clr    (resume_clr),
    .cmd_wr_in     (cmd_wr_in),
    .dslot_vld_in  (dslot_vld_in),
    .cmd_wr_out    (cmd_wr_out),
    .cmd_addr_out  (cmd_addr_out),
    .cmd_data_out  (cmd_data_out),
    .dslot_vld_out (dslot_vld_out),
    .sync_out      (sync_out),
    .resume_irq    (resume_irq),
    .link_active   (link_active)
);

// File: tb/alink_pwr_seq_tb.sv
module alink_pwr_seq_tb;
    localparam int US     = 50;
    localparam int EDGE_N = 2;
    localparam int NSLOT  = 10;
    localparam int SW     = 20;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pd_req = 0, frame_done = 0, warm_go = 0, resume_en = 0, resume_clr = 0;
    logic sdata_in = 0, bitclk_in = 0;
    logic cmd_wr_in = 0;
    logic [6:0] cmd_addr_in = '0;
    logic [15:0] cmd_data_in = '0;
    logic [NSLOT*SW-1:0] dslot_in = '0;
    logic [NSLOT-1:0] dslot_vld_in = '0;
    logic cmd_wr_out;
    logic [6:0] cmd_addr_out;
    logic [15:0] cmd_data_out;
    logic [NSLOT*SW-1:0] dslot_out;
    logic [NSLOT-1:0] dslot_vld_out;
    logic sync_out, resume_irq, link_active;

    int n_chk = 0;
    int n_err = 0;

    always #10 clk = ~clk;

    alink_pwr_seq #(.US_CYC(US), .EDGE_N(EDGE_N), .NSLOT(NSLOT), .SW(SW)) u_dut (
        .clk(clk), .rst(rst), .pd_req(pd_req), .frame_done(frame_done),
        .warm_go(warm_go), .resume_en(resume_en), .resume_clr(resume_clr),
        .sdata_in(sdata_in), .bitclk_in(bitclk_in),
        .cmd_wr_in(cmd_wr_in), .cmd_addr_in(cmd_addr_in), .cmd_data_in(cmd_data_in),
        .dslot_in(dslot_in), .dslot_vld_in(dslot_vld_in),
        .cmd_wr_out(cmd_wr_out), .cmd_addr_out(cmd_addr_out), .cmd_data_out(cmd_data_out),
        .dslot_out(dslot_out), .dslot_vld_out(dslot_vld_out),
        .sync_out(sync_out), .resume_irq(resume_irq), .link_active(link_active)
    );

    typedef struct packed {
        logic [6:0]  a;
        logic [15:0] d;
        logic        w;
        logic [19:0] fill;
        logic [9:0]  v;
    } vec_t;

    localparam vec_t VEC [4] = '{
        '{7'h02, 16'h1234, 1'b1, 20'hABCDE, 10'h3FF},
        '{7'h7F, 16'hFFFF, 1'b0, 20'h00001, 10'h001},
        '{7'h26, 16'h0000, 1'b1, 20'h5A5A5, 10'h2AA},
        '{7'h00, 16'h8001, 1'b0, 20'hFFFFF, 10'h155}
    };

    task automatic check(string req, logic [255:0] act, logic [255:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bclk_pulses(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) bitclk_in = 1'b1;
            repeat (3) @(negedge clk);
            bitclk_in = 1'b0;
            repeat (3) @(negedge clk);
        end
    endtask

    task automatic enter_sleep();
        @(negedge clk) pd_req = 1'b1;
        @(negedge clk) pd_req = 1'b0;
        frame_done = 1'b1;
        @(negedge clk) frame_done = 1'b0;
    endtask

    task automatic wake_up_link();
        @(negedge clk) warm_go = 1'b1;
        @(negedge clk) warm_go = 1'b0;
        repeat (US + 4) @(negedge clk);
        sdata_in = 1'b0;
        bclk_pulses(EDGE_N);
        repeat (8) @(negedge clk);
    endtask

    initial begin
        #3_000_000;
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 active", 256'(link_active), 256'(1));
        check("R1 sync", 256'(sync_out), 256'(0));
        check("R1 irq", 256'(resume_irq), 256'(0));

        // R2 table of passthrough vectors
        foreach (VEC[i]) begin
            @(negedge clk);
            cmd_addr_in  = VEC[i].a;
            cmd_data_in  = VEC[i].d;
            cmd_wr_in    = VEC[i].w;
            dslot_in     = {NSLOT{VEC[i].fill}};
            dslot_vld_in = VEC[i].v;
            #1;
            check("R2 cmd", 256'({cmd_wr_out, cmd_addr_out, cmd_data_out}),
                  256'({VEC[i].w, VEC[i].a, VEC[i].d}));
            check("R2 data", 256'(dslot_out), 256'({NSLOT{VEC[i].fill}}));
            check("R2 vld", 256'(dslot_vld_out), 256'(VEC[i].v));
        end

        // R11 inbound data in run state has no effect
        resume_en = 1'b1;
        @(negedge clk) sdata_in = 1'b1;
        repeat (3 * US) @(negedge clk);
        check("R11 no irq while running", 256'(resume_irq), 256'(0));
        check("R11 still running", 256'(link_active), 256'(1));
        sdata_in = 1'b0;
        repeat (4) @(negedge clk);

        // R3 power-down frame
        cmd_wr_in = 1'b1; cmd_addr_in = 7'h11; cmd_data_in = 16'hBEEF;
        dslot_in = {NSLOT{20'h12345}}; dslot_vld_in = '1;
        pd_req = 1'b1;
        @(negedge clk) pd_req = 1'b0;
        check("R3 cmd", 256'({cmd_wr_out, cmd_addr_out, cmd_data_out}),
              256'({1'b1, 7'h26, 16'h1000}));
        check("R3 data", 256'(dslot_out), 256'(0));
        check("R3 vld", 256'(dslot_vld_out), 256'(0));
        pd_req = 1'b1;
        @(negedge clk) pd_req = 1'b0;
        check("R11 pd_req during frame", 256'({cmd_wr_out, cmd_addr_out, cmd_data_out}),
              256'({1'b1, 7'h26, 16'h1000}));
        frame_done = 1'b1;
        @(negedge clk) frame_done = 1'b0;
        // R4 asleep
        check("R4 inactive", 256'(link_active), 256'(0));
        check("R4 cmd muted", 256'({cmd_wr_out, cmd_addr_out, cmd_data_out}), 256'(0));
        check("R4 data muted", 256'({dslot_out, dslot_vld_out}), 256'(0));
        bclk_pulses(4);
        repeat (8) @(negedge clk);
        check("R4 bitclk ignored", 256'(link_active), 256'(0));
        pd_req = 1'b1;
        @(negedge clk) pd_req = 1'b0;
        check("R11 pd_req asleep", 256'(cmd_wr_out), 256'(0));

        // R5 short pulse
        sdata_in = 1'b1;
        repeat (US / 2) @(negedge clk);
        sdata_in = 1'b0;
        repeat (2 * US) @(negedge clk);
        check("R5 short pulse", 256'(resume_irq), 256'(0));

        // R6 qualification timing
        sdata_in = 1'b1;
        repeat (3 + US) @(posedge clk);
        @(negedge clk);
        check("R6 before qualify", 256'(resume_irq), 256'(0));
        @(posedge clk);
        @(negedge clk);
        check("R6 at qualify", 256'(resume_irq), 256'(1));

        // R8 sticky and clear
        repeat (10) @(negedge clk);
        check("R8 sticky", 256'(resume_irq), 256'(1));
        resume_clr = 1'b1;
        @(negedge clk) resume_clr = 1'b0;
        check("R8 cleared", 256'(resume_irq), 256'(0));

        // R9 warm reset pulse
        warm_go = 1'b1;
        @(posedge clk);
        @(negedge clk) warm_go = 1'b0;
        check("R9 sync start", 256'(sync_out), 256'(1));
        repeat (US - 1) @(posedge clk);
        @(negedge clk);
        check("R9 sync last cycle", 256'(sync_out), 256'(1));
        @(posedge clk);
        @(negedge clk);
        check("R9 sync end", 256'(sync_out), 256'(0));
        sdata_in = 1'b0;

        // R10 bit clock recovery
        repeat (10) @(negedge clk);
        check("R10 no clock yet", 256'(link_active), 256'(0));
        bclk_pulses(EDGE_N - 1);
        repeat (8) @(negedge clk);
        check("R10 too few edges", 256'(link_active), 256'(0));
        bclk_pulses(1);
        repeat (8) @(negedge clk);
        check("R10 running again", 256'(link_active), 256'(1));

        // R7 resume disabled
        resume_en = 1'b0;
        enter_sleep();
        sdata_in = 1'b1;
        repeat (3 * US) @(negedge clk);
        check("R7 disabled irq", 256'(resume_irq), 256'(0));
        wake_up_link();
        check("R7 link back", 256'(link_active), 256'(1));

        // R8 set wins over clear
        resume_en = 1'b1;
        enter_sleep();
        resume_clr = 1'b1;
        sdata_in = 1'b1;
        repeat (3 + US) @(posedge clk);
        @(negedge clk);
        check("R8 clear held", 256'(resume_irq), 256'(0));
        @(posedge clk);
        @(negedge clk);
        check("R8 set wins", 256'(resume_irq), 256'(1));
        @(posedge clk);
        @(negedge clk);
        check("R8 clear after", 256'(resume_irq), 256'(0));
        resume_clr = 1'b0;
        wake_up_link();
        check("R10 final run", 256'(link_active), 256'(1));

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule